// File: doc/BRIEF.md
# Per-Crossing Stub Frame Serializer

This block takes the stub candidates found in one bunch crossing and turns them into one fixed 40-bit frame. It sends that frame on ten parallel serial lines, each carrying four bits per crossing. Each stub has an 8-bit bottom-layer cluster address and a 5-bit bend value. The address is in half-strip units: a two-strip cluster takes its midpoint, and a one- or three-strip cluster takes its centre strip. The bend is a two's-complement value in half strips. It gives where the matching top-layer cluster sits in the window, relative to the bottom address plus the programmed offset. The block does not interpret either field; it only moves them.

A frame holds three stub slots and one bit of unsparsified triggered readout data. When more than three stubs are offered, the three with the lowest addresses are kept and the others are dropped. Slots left empty carry an all-ones address, a value no real cluster can have, so the receiver sees them as invalid.

The block runs on the serial bit clock, which has four periods per crossing. A free-running phase counter marks the crossing boundary. A one-cycle strobe marks the first bit period of every frame.

Top module: `stub_frame_serializer`

## Requirements
- R1: After reset, every serial line is 0 and the frame strobe is low until the first frame is sent.
- R2: The crossing period is 4 clocks. Inputs are sampled on the fourth rising edge after reset and on every fourth edge after that. The captured frame starts on the lines in the next cycle. The frame strobe is high during that first bit period only, so strobes are exactly 4 clocks apart.
- R3: The frame word W[39:0] is laid out as W[39:32] slot 0 address, W[31:27] slot 0 bend, W[26:19] slot 1 address, W[18:14] slot 1 bend, W[13:6] slot 2 address, W[5:1] slot 2 bend.
- R4: Line j (0..9) sends W[4j+3], W[4j+2], W[4j+1], W[4j] in the four bit periods of the frame, in that order.
- R5: Slots are filled with the eligible candidates in ascending address order. Among equal addresses the lower candidate index goes first. Only the three lowest are sent.
- R6: An unused slot carries address 8'hFF and bend 5'h00.
- R7: A candidate whose valid flag is 0, or whose address is 8'hFF, is ignored and takes no slot.
- R8: W[0] is the readout bit sampled at the capture edge.
- R9: An input change between capture edges does not alter the frame currently on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (4 periods per crossing) |
| rstN | input | 1 | Asynchronous active-low reset |
| candValid | input | NUM_CAND | Per-candidate valid flag |
| candAddr | input | NUM_CAND*8 | Candidate addresses, candidate i at bits [8i+7:8i] |
| candBend | input | NUM_CAND*5 | Candidate bends, candidate i at bits [5i+4:5i] |
| readoutBit | input | 1 | Unsparsified triggered readout bit for the crossing |
| serLine | output | 10 | Serial output lines |
| frameStrobe | output | 1 | High in the first bit period of each frame |

## Verification
Inputs present at a capture edge (phase 3) show up on the lines in the very next cycle, which is the cycle when the strobe rises. Each of the four bits then stays on its line for one clock. The bench keeps a behavioural model with its own phase count, advanced on the same rising edges. It compares every line and the strobe at each falling edge, so every result is checked in the exact cycle it is due. Directed cases set inputs at a strobe, wait one full crossing, and rebuild the word from the four following samples. One case changes the inputs in the middle of a frame to show that the frame already on the lines keeps its content.

// File: rtl/stub_ser_pkg.sv
package stub_ser_pkg;
  localparam int ADDR_W        = 8;
  localparam int BEND_W        = 5;
  localparam int STUB_W        = ADDR_W + BEND_W;
  localparam int SLOTS         = 3;
  localparam int LINES         = 10;
  localparam int BITS_PER_LINE = 4;
  localparam int FRAME_W       = SLOTS * STUB_W + 1;
  localparam int PH_W          = $clog2(BITS_PER_LINE);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BEND_W-1:0] bend;
  } stub_t;

  typedef struct packed {
    logic            load;
    logic            frameStart;
    logic [PH_W-1:0] bitSel;
  } ser_ctrl_t;
endpackage

// File: rtl/stub_ser_ctrl.sv
module stub_ser_ctrl
  import stub_ser_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output ser_ctrl_t ctl
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(BITS_PER_LINE - 1);

  logic [PH_W-1:0] phase;
  logic            started;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      started <= 1'b0;
    end else begin
      phase   <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
      if (phase == LAST_PH) started <= 1'b1;
    end
  end

  always_comb begin
    ctl.load       = (phase == LAST_PH);
    ctl.frameStart = started && (phase == '0);
    ctl.bitSel     = phase;
  end
endmodule

// File: rtl/stub_ser_select.sv
module stub_ser_select
  import stub_ser_pkg::*;
#(
  parameter int NUM_CAND = 6
) (
  input  logic [NUM_CAND-1:0]        candValid,
  input  logic [NUM_CAND*ADDR_W-1:0] candAddr,
  input  logic [NUM_CAND*BEND_W-1:0] candBend,
  output stub_t [SLOTS-1:0]          slotOut
);
  localparam int RANK_W = $clog2(NUM_CAND + 1);

  logic [NUM_CAND-1:0] eligible;
  logic [RANK_W-1:0]   rank [NUM_CAND];

  // A candidate counts only when flagged valid and not carrying the marker address
  always_comb begin
    for (int i = 0; i < NUM_CAND; i++)
      eligible[i] = candValid[i] && (candAddr[i*ADDR_W +: ADDR_W] != '1);
  end

  // Rank = number of eligible candidates ordered ahead (lower address, then lower index)
  generate
    for (genvar i = 0; i < NUM_CAND; i++) begin : g_rank
      always_comb begin
        rank[i] = '0;
        for (int j = 0; j < NUM_CAND; j++) begin
          if (eligible[j] && (j != i)) begin
            if ((candAddr[j*ADDR_W +: ADDR_W] < candAddr[i*ADDR_W +: ADDR_W]) ||
                ((candAddr[j*ADDR_W +: ADDR_W] == candAddr[i*ADDR_W +: ADDR_W]) && (j < i)))
              rank[i] = rank[i] + RANK_W'(1);
          end
        end
      end
    end
  endgenerate

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_comb begin
        slotOut[s].addr = '1;
        slotOut[s].bend = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
          if (eligible[i] && (rank[i] == RANK_W'(s))) begin
            slotOut[s].addr = candAddr[i*ADDR_W +: ADDR_W];
            slotOut[s].bend = candBend[i*BEND_W +: BEND_W];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stub_ser_datapath.sv
module stub_ser_datapath
  import stub_ser_pkg::*;
#(
  parameter int NUM_CAND = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ser_ctrl_t                  ctl,
  input  logic [NUM_CAND-1:0]        candValid,
  input  logic [NUM_CAND*ADDR_W-1:0] candAddr,
  input  logic [NUM_CAND*BEND_W-1:0] candBend,
  input  logic                       readoutBit,
  output logic [LINES-1:0]           serLine
);
  stub_t [SLOTS-1:0]  slots;
  logic [FRAME_W-1:0] nextFrame;
  logic [FRAME_W-1:0] frameReg;

  stub_ser_select #(.NUM_CAND(NUM_CAND)) u_sel (
    .candValid (candValid),
    .candAddr  (candAddr),
    .candBend  (candBend),
    .slotOut   (slots)
  );

  always_comb begin
    nextFrame    = '0;
    nextFrame[0] = readoutBit;
    for (int s = 0; s < SLOTS; s++)
      nextFrame[FRAME_W-1 - s*STUB_W -: STUB_W] = slots[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         frameReg <= '0;
    else if (ctl.load) frameReg <= nextFrame;
  end

  // Each line walks its own nibble from high bit to low bit
  always_comb begin
    for (int j = 0; j < LINES; j++) begin
      int idx;
      idx = j*BITS_PER_LINE + (BITS_PER_LINE - 1) - int'(ctl.bitSel);
      serLine[j] = frameReg[idx];
    end
  end
endmodule

// File: rtl/stub_frame_serializer.sv
module stub_frame_serializer
  import stub_ser_pkg::*;
#(
  parameter int NUM_CAND = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CAND-1:0]        candValid,
  input  logic [NUM_CAND*ADDR_W-1:0] candAddr,
  input  logic [NUM_CAND*BEND_W-1:0] candBend,
  input  logic                       readoutBit,
  output logic [LINES-1:0]           serLine,
  output logic                       frameStrobe
);
  ser_ctrl_t ctl;

  stub_ser_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl)
  );

  stub_ser_datapath #(.NUM_CAND(NUM_CAND)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .candValid  (candValid),
    .candAddr   (candAddr),
    .candBend   (candBend),
    .readoutBit (readoutBit),
    .serLine    (serLine)
  );

  assign frameStrobe = ctl.frameStart;
endmodule

// File: rtl/stub_frame_serializer_chk.sv
module stub_frame_serializer_chk
  import stub_ser_pkg::*;
#(
  parameter int NUM_CAND = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CAND-1:0] candValid,
  input logic                readoutBit,
  input logic [LINES-1:0]    serLine,
  input logic                frameStrobe,
  input logic                load,
  input logic [FRAME_W-1:0]  frameReg
);
  logic seenStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            seenStrobe <= 1'b0;
    else if (frameStrobe) seenStrobe <= 1'b1;
  end

  a_r1_quiet_lines: assert property (@(posedge clk) disable iff (!rstN)
    (!seenStrobe && !frameStrobe) |-> (serLine == '0));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

  a_r2_strobe_period: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> ##4 frameStrobe);

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> (serLine[LINES-1] == frameReg[FRAME_W-1]));

  a_r6_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
    (load && (candValid == '0)) |=> (frameReg[FRAME_W-1 -: ADDR_W] == '1));

  a_r8_readout_bit: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (frameReg[0] == $past(readoutBit)));
endmodule

bind stub_frame_serializer stub_frame_serializer_chk #(.NUM_CAND(NUM_CAND)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .candValid   (candValid),
  .readoutBit  (readoutBit),
  .serLine     (serLine),
  .frameStrobe (frameStrobe),
  .load        (ctl.load),
  .frameReg    (u_dp.frameReg)
);

// File: tb/stub_frame_serializer_bench.sv
`timescale 1ns/1ps
module stub_frame_serializer_bench;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] candValid = '0;
  logic [NC*8-1:0] candAddr = '0;
  logic [NC*5-1:0] candBend = '0;
  logic          readoutBit = 1'b0;
  logic [9:0]    serLine;
  logic          frameStrobe;

  int    tests = 0;
  int    fails = 0;
  string curReq = "R1";

  stub_frame_serializer #(.NUM_CAND(NC)) u_stub_frame_serializer (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candAddr(candAddr),
    .candBend(candBend), .readoutBit(readoutBit), .serLine(serLine),
    .frameStrobe(frameStrobe)
  );

  always #2 clk = ~clk;

  // Behavioural reference: pick three lowest addresses by repeated minimum search
  function automatic logic [39:0] refFrame();
    logic [39:0] w;
    bit taken [NC];
    w = '0;
    w[0] = readoutBit;
    for (int i = 0; i < NC; i++) taken[i] = 0;
    for (int s = 0; s < 3; s++) begin
      int best;
      int a;
      int b;
      best = -1;
      for (int i = 0; i < NC; i++) begin
        int ai;
        ai = int'(candAddr[i*8 +: 8]);
        if (candValid[i] && ai != 255 && !taken[i])
          if (best < 0 || ai < int'(candAddr[best*8 +: 8])) best = i;
      end
      if (best >= 0) begin
        taken[best] = 1;
        a = int'(candAddr[best*8 +: 8]);
        b = int'(candBend[best*5 +: 5]);
      end else begin
        a = 255;
        b = 0;
      end
      w = w | (40'((a * 32) + b) << (27 - 13*s));
    end
    return w;
  endfunction

  int          mPh = 0;
  logic [39:0] mFrame = '0;
  bit          mStarted = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mFrame = '0; mStarted = 0;
    end else begin
      if (mPh == 3) begin
        mFrame = refFrame();
        mStarted = 1;
      end
      mPh = (mPh + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock, compared against the model at the falling edge
  task automatic tick();
    logic [9:0] expL;
    bit expS;
    @(negedge clk);
    for (int j = 0; j < 10; j++) expL[j] = mFrame[4*j + 3 - mPh];
    expS = mStarted && (mPh == 0);
    if (rstN)
      check((serLine === expL) && (frameStrobe === expS), curReq, "per-cycle lines/strobe",
            {53'd0, frameStrobe, serLine}, {53'd0, expS, expL});
  endtask

  task automatic waitStrobe();
    int n;
    n = 0;
    do begin tick(); n++; end while (!frameStrobe && n < 20);
  endtask

  task automatic setCand(input int i, input bit v, input int a, input int b);
    candValid[i] = v;
    candAddr[i*8 +: 8] = 8'(a);
    candBend[i*5 +: 5] = 5'(b);
  endtask

  // Called at a strobe cycle; rebuilds the word from four bit periods
  task automatic captureFrame(output logic [39:0] w, input bit mutate);
    w = '0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) tick();
      for (int j = 0; j < 10; j++) w[4*j + 3 - k] = serLine[j];
      if (mutate && k == 0) begin
        for (int i = 0; i < NC; i++) setCand(i, 1, 0, 31);
        readoutBit = ~readoutBit;
      end
    end
  endtask

  initial begin
    logic [39:0] w;
    logic [39:0] saved;
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(serLine === 10'd0 && frameStrobe === 1'b0, "R1", "lines during reset",
          {53'd0, frameStrobe, serLine}, 64'd0);
    rstN = 1'b1;
    tick();
    check(serLine === 10'd0 && frameStrobe === 1'b0, "R1", "lines after reset",
          {53'd0, frameStrobe, serLine}, 64'd0);
    curReq = "R2";
    waitStrobe();
    n = 0;
    do begin tick(); n++; end while (!frameStrobe && n < 20);
    check(n == 4, "R2", "strobe spacing", 64'(n), 64'd4);

    // R3 and R4: one stub
    curReq = "R3";
    setCand(2, 1, 8'h5A, 5'h13);
    readoutBit = 1'b0;
    waitStrobe();
    captureFrame(w, 0);
    check(w[39:32] == 8'h5A, "R3", "slot0 address", 64'(w[39:32]), 64'h5A);
    check(w[31:27] == 5'h13, "R3", "slot0 bend", 64'(w[31:27]), 64'h13);
    check(w == refFrame(), "R4", "line-to-word mapping", 64'(w), 64'(refFrame()));

    // R5 ordering with tie, plus R9 mid-frame change
    curReq = "R5";
    waitStrobe();
    setCand(0, 1, 8'h40, 1); setCand(1, 1, 8'h10, 2); setCand(2, 1, 8'h30, 3);
    setCand(3, 1, 8'h10, 4); setCand(4, 1, 8'h80, 5); setCand(5, 1, 8'h20, 6);
    saved = refFrame();
    waitStrobe();
    curReq = "R9";
    captureFrame(w, 1);
    check(w[39:27] == {8'h10, 5'd2}, "R5", "slot0 lowest, lower index on tie",
          64'(w[39:27]), 64'({8'h10, 5'd2}));
    check(w[26:14] == {8'h10, 5'd4}, "R5", "slot1 tie partner", 64'(w[26:14]), 64'({8'h10, 5'd4}));
    check(w[13:1] == {8'h20, 5'd6}, "R5", "slot2 third lowest", 64'(w[13:1]), 64'({8'h20, 5'd6}));
    check(w == saved, "R9", "frame held despite mid-frame change", 64'(w), 64'(saved));

    // R6 and R8: empty crossing with readout bit set
    curReq = "R6";
    waitStrobe();
    candValid = '0;
    readoutBit = 1'b1;
    waitStrobe();
    captureFrame(w, 0);
    check(w == 40'hFF07F83FC1, "R6", "empty slots", 64'(w), 64'h FF07F83FC1);
    check(w[0] == 1'b1, "R8", "readout bit", 64'(w[0]), 64'd1);

    // R7: marker address and invalid flag ignored
    curReq = "R7";
    waitStrobe();
    setCand(0, 1, 8'hFF, 7); setCand(1, 1, 8'h03, 1); setCand(4, 0, 8'h01, 9);
    readoutBit = 1'b0;
    waitStrobe();
    captureFrame(w, 0);
    check(w[39:27] == {8'h03, 5'd1}, "R7", "slot0 skips ignored", 64'(w[39:27]), 64'({8'h03, 5'd1}));
    check(w[26:14] == {8'hFF, 5'd0}, "R7", "slot1 empty", 64'(w[26:14]), 64'({8'hFF, 5'd0}));
    check(w[0] == 1'b0, "R8", "readout bit cleared", 64'(w[0]), 64'd0);

    // R5: random candidates, compared every cycle
    curReq = "R5";
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < NC; i++)
        setCand(i, 1'($urandom), int'($urandom % 24) * ((c % 5 == 0) ? 11 : 1), int'($urandom % 32));
      readoutBit = 1'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule